// File: doc/BRIEF.md
# Gain-Loop and Slicer-Threshold Mode Sequencer

This block picks, every reference-clock cycle, which of four drive currents is applied to the gain-control node of an amplitude-keyed receiver, and whether the slicing-threshold integrator is frozen. It observes three things: a shutdown request, the sliced data bit, and a comparator flag that is high while the filtered baseband amplitude sits above its target. The analog current sources and capacitors sit outside the block and take the one-hot drive vector and the hold flag directly.

After power-up or shutdown the node is pumped with the large charge current until the sliced data goes high for the first time. That phase does not return until the next shutdown or reset. From then on the loop tracks. It bleeds the node slowly down while the amplitude is above target and slowly up otherwise. When the above-target flag persists for a programmable run of cycles, the strong fast-attack discharge takes over. It stays on until the flag drops. Separately, a run of low data samples of programmable length freezes the threshold integrator, and the first high data sample releases it.

Top module: `agc_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on every clock edge that samples `shdn` high, the outputs take `gain_drv` = 4'b0001 and `thr_hold` = 0. A released `rst_n` passes through a two-stage synchronizer, so the first two edges after release still act as reset.
- R2: `gain_drv` always has exactly one bit set. The bit positions are: bit 0 fast charge, bit 1 fast-attack discharge, bit 2 slow discharge, bit 3 slow charge.
- R3: Fast charge (bit 0) remains selected until the first edge that samples `slice_data` high. From that edge the block is in tracking.
- R4: Once fast charge has ended, bit 0 is never set again until shutdown or reset.
- R5: In tracking, each edge selects slow discharge (bit 2) when `agc_above` is sampled high and slow charge (bit 3) when it is sampled low.
- R6: Fast attack (bit 1) is selected at the edge where `agc_above` has been sampled high on `ATK_RUN` consecutive edges, all counted in tracking. High samples taken during the fast-charge phase do not count toward this run.
- R7: Fast attack ends at the first edge that samples `agc_above` low. That edge selects slow charge, and the consecutive-high count restarts from zero.
- R8: `thr_hold` rises at the edge of the `HOLD_RUN`-th consecutive low sample of `slice_data`, in any mode other than shutdown, and stays high while the data stays low.
- R9: `thr_hold` falls at the first edge that samples `slice_data` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| shdn | input | 1 | Shutdown request, active high, sampled on the clock |
| slice_data | input | 1 | Sliced demodulated data bit |
| agc_above | input | 1 | Comparator flag: baseband amplitude above target |
| gain_drv | output | 4 | One-hot gain-node drive select (bit 0 fast charge, 1 fast attack, 2 slow discharge, 3 slow charge) |
| thr_hold | output | 1 | Freeze request for the threshold integrator |

## Verification
A mode register stuck in the wrong state shows at `gain_drv` on the very next edge. Tracking and fast attack select different bits, and the fast-charge phase owns bit 0 alone. A miscounting run counter shows only at the end of a run: the attack bit or the hold flag moves one or more edges early or late. For this reason the stimulus includes runs one sample short of each limit, runs exactly at each limit, and runs well beyond each limit. Every cycle is compared with a behavioural model, so any of these faults appears in the same cycle it reaches the ports.

// File: rtl/agc_mode_pkg.sv
package agc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_PWRUP  = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_ATTACK = 2'd2
  } agc_mode_e;

  localparam int DRV_W = 4;

  localparam int BIT_FAST_CHG = 0;
  localparam int BIT_FAST_ATK = 1;
  localparam int BIT_SLOW_DIS = 2;
  localparam int BIT_SLOW_CHG = 3;

  localparam logic [DRV_W-1:0] DRV_FAST_CHG = DRV_W'(1) << BIT_FAST_CHG;
  localparam logic [DRV_W-1:0] DRV_FAST_ATK = DRV_W'(1) << BIT_FAST_ATK;
  localparam logic [DRV_W-1:0] DRV_SLOW_DIS = DRV_W'(1) << BIT_SLOW_DIS;
  localparam logic [DRV_W-1:0] DRV_SLOW_CHG = DRV_W'(1) << BIT_SLOW_CHG;

endpackage

// File: rtl/agc_rst_sync.sv
module agc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/agc_run_cnt.sv
module agc_run_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic near,
  output logic full
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V  = W'(LIMIT);
  localparam logic [W-1:0] NEAR_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_ce = 1'b1;
      cnt_d  = '0;
    end else if (cnt_en && (cnt_q != LIM_V)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign near = (cnt_q == NEAR_V);
  assign full = (cnt_q == LIM_V);

endmodule

// File: rtl/agc_gain_seq.sv
module agc_gain_seq
  import agc_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn,
  input  logic             slice_data,
  input  logic             agc_above,
  input  logic             atk_near,
  output agc_mode_e        mode,
  output logic [DRV_W-1:0] gain_drv
);

  agc_mode_e        mode_q;
  agc_mode_e        mode_d;
  logic [DRV_W-1:0] drv_q;
  logic [DRV_W-1:0] drv_d;

  always_comb begin
    mode_d = mode_q;
    if (shdn) begin
      mode_d = MODE_PWRUP;
    end else begin
      case (mode_q)
        MODE_PWRUP:  if (slice_data) mode_d = MODE_TRACK;
        MODE_TRACK:  if (agc_above && atk_near) mode_d = MODE_ATTACK;
        MODE_ATTACK: if (!agc_above) mode_d = MODE_TRACK;
        default:     mode_d = MODE_PWRUP;
      endcase
    end
  end

  always_comb begin
    case (mode_d)
      MODE_PWRUP:  drv_d = DRV_FAST_CHG;
      MODE_ATTACK: drv_d = DRV_FAST_ATK;
      default:     drv_d = agc_above ? DRV_SLOW_DIS : DRV_SLOW_CHG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PWRUP;
      drv_q  <= DRV_FAST_CHG;
    end else begin
      mode_q <= mode_d;
      drv_q  <= drv_d;
    end
  end

  assign mode     = mode_q;
  assign gain_drv = drv_q;

endmodule

// File: rtl/agc_mode_ctrl.sv
module agc_mode_ctrl
  import agc_mode_pkg::*;
#(
  parameter int HOLD_RUN = 54000,
  parameter int ATK_RUN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn,
  input  logic       slice_data,
  input  logic       agc_above,
  output logic [3:0] gain_drv,
  output logic       thr_hold
);

  logic      rst_q_n;
  agc_mode_e mode;
  logic      atk_near;
  logic      atk_full_unused;
  logic      low_near_unused;
  logic      low_full;
  logic      atk_clr;
  logic      low_clr;

  agc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign atk_clr = shdn || !agc_above || (mode != MODE_TRACK);
  assign low_clr = shdn || slice_data;

  agc_run_cnt #(.LIMIT(ATK_RUN)) u_atk_run (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (atk_clr),
    .cnt_en (1'b1),
    .near   (atk_near),
    .full   (atk_full_unused)
  );

  agc_run_cnt #(.LIMIT(HOLD_RUN)) u_low_run (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (low_clr),
    .cnt_en (1'b1),
    .near   (low_near_unused),
    .full   (low_full)
  );

  agc_gain_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .shdn       (shdn),
    .slice_data (slice_data),
    .agc_above  (agc_above),
    .atk_near   (atk_near),
    .mode       (mode),
    .gain_drv   (gain_drv)
  );

  assign thr_hold = low_full;

endmodule

// File: rtl/agc_mode_ctrl_chk.sv
module agc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       shdn,
  input logic       slice_data,
  input logic       agc_above,
  input logic [3:0] gain_drv,
  input logic       thr_hold
);

  AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(gain_drv) == 1); // R2
  AST_SHDN_TO_PWRUP: assert property (@(posedge clk) disable iff (!rst_q_n)
    shdn |=> (gain_drv == 4'b0001) && !thr_hold); // R1
  AST_FCHG_LEAVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gain_drv[0] && slice_data && !shdn) |=> !gain_drv[0]); // R3
  AST_FCHG_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!gain_drv[0] && !shdn) |=> !gain_drv[0]); // R4
  AST_TRACK_LOW_CHARGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((gain_drv[2] || gain_drv[3]) && !agc_above && !shdn) |=> gain_drv[3]); // R5
  AST_NO_ATK_FROM_PWRUP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gain_drv[0] && !shdn) |=> !gain_drv[1]); // R6
  AST_ATK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(gain_drv[1]) |-> $past(agc_above)); // R6
  AST_ATK_LEAVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gain_drv[1] && !agc_above && !shdn) |=> gain_drv[3]); // R7
  AST_HOLD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(thr_hold) |-> $past(!slice_data)); // R8
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    slice_data |=> !thr_hold); // R9

endmodule

bind agc_mode_ctrl agc_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .shdn       (shdn),
  .slice_data (slice_data),
  .agc_above  (agc_above),
  .gain_drv   (gain_drv),
  .thr_hold   (thr_hold)
);

// File: tb/agc_mode_ctrl_tb_top.sv
module agc_mode_ctrl_tb_top;

  localparam int HOLD_N = 20;
  localparam int ATK_N  = 4;

  logic       clk;
  logic       rst_n;
  logic       shdn;
  logic       slice_data;
  logic       agc_above;
  logic [3:0] gain_drv;
  logic       thr_hold;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  agc_mode_ctrl #(.HOLD_RUN(HOLD_N), .ATK_RUN(ATK_N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn       (shdn),
    .slice_data (slice_data),
    .agc_above  (agc_above),
    .gain_drv   (gain_drv),
    .thr_hold   (thr_hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference: 0 power-up, 1 tracking, 2 attack
  int m_st   = 0;
  int m_arun = 0;
  int m_lrun = 0;
  int m_rs   = 0;
  int m_drv  = 1;
  int m_hold = 0;

  always @(posedge clk) begin
    bit in_reset;
    in_reset = 1'b0;
    if (!rst_n) begin
      m_rs = 0;
      in_reset = 1'b1;
    end else if (m_rs < 2) begin
      m_rs++;
      in_reset = 1'b1;
    end
    if (in_reset || shdn) begin
      m_st = 0; m_arun = 0; m_lrun = 0;
    end else begin
      if (slice_data) m_lrun = 0;
      else if (m_lrun < HOLD_N) m_lrun++;
      if (m_st == 0) begin
        if (slice_data) m_st = 1;
      end else if (m_st == 1) begin
        if (agc_above) begin
          m_arun++;
          if (m_arun >= ATK_N) begin m_st = 2; m_arun = 0; end
        end else m_arun = 0;
      end else begin
        if (!agc_above) m_st = 1;
      end
    end
    if (m_st == 0) m_drv = 1;
    else if (m_st == 2) m_drv = 2;
    else m_drv = (!in_reset && !shdn && agc_above) ? 4 : 8;
    m_hold = (m_lrun >= HOLD_N) ? 1 : 0;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_model();
    string dtag;
    dtag = (m_st == 0) ? "R3 drive" : (m_st == 2) ? "R6 drive" : "R5 drive";
    chk(dtag, int'(gain_drv), m_drv);
    chk("R8 hold", int'(thr_hold), m_hold);
    chk("R2 onehot", $countones(gain_drv), 1);
  endtask

  // Inputs are applied at a falling edge; outputs are compared at the next one.
  task automatic step(input bit s, input bit d, input bit a);
    shdn = s; slice_data = d; agc_above = a;
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shdn = 1'b1; slice_data = 1'b0; agc_above = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive", int'(gain_drv), 1);
    chk("R1 reset hold", int'(thr_hold), 0);
    rst_n = 1'b1;
    repeat (3) step(1, 0, 0);
    // power-up phase: data low, comparator high; no attack, hold rises
    for (int i = 0; i < HOLD_N - 1; i++) step(0, 0, 1);
    chk("R8 hold one short", int'(thr_hold), 0);
    step(0, 0, 1);
    chk("R8 hold at limit", int'(thr_hold), 1);
    chk("R6 no attack in power-up", int'(gain_drv), 1);
    chk("R3 still fast charge", int'(gain_drv), 1);
    // first high data sample
    step(0, 1, 0);
    chk("R3 fast charge ended", int'(gain_drv), 8);
    chk("R9 hold released", int'(thr_hold), 0);
    repeat (30) step(0, 0, 0);
    chk("R4 fast charge absent", int'(gain_drv[0]), 0);
    // run one short of attack
    for (int i = 0; i < ATK_N - 1; i++) step(0, 1, 1);
    chk("R5 slow discharge", int'(gain_drv), 4);
    step(0, 1, 0);
    chk("R5 slow charge", int'(gain_drv), 8);
    for (int i = 0; i < ATK_N - 1; i++) step(0, 1, 1);
    chk("R6 no attack before limit", int'(gain_drv), 4);
    step(0, 1, 1);
    chk("R6 attack at limit", int'(gain_drv), 2);
    repeat (5) step(0, 1, 1);
    chk("R6 attack held", int'(gain_drv), 2);
    step(0, 1, 0);
    chk("R7 attack exit", int'(gain_drv), 8);
    for (int i = 0; i < ATK_N - 1; i++) step(0, 1, 1);
    chk("R7 count restarted", int'(gain_drv), 4);
    step(0, 1, 1);
    chk("R6 attack again", int'(gain_drv), 2);
    step(1, 1, 1);
    chk("R1 shutdown in attack", int'(gain_drv), 1);
    step(0, 0, 0);
    step(0, 1, 1);
    // randomized runs with occasional shutdown and reset
    begin
      bit d, a, s;
      d = 1'b0; a = 1'b0; s = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(0, 11) == 0) d = ~d;
        if ($urandom_range(0, 4) == 0) a = ~a;
        s = ($urandom_range(0, 399) == 0);
        if ($urandom_range(0, 2999) == 0) begin
          rst_n = 1'b0;
          step(s, d, a);
          chk("R1 async reset", int'(gain_drv), 1);
          rst_n = 1'b1;
        end else begin
          step(s, d, a);
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule